// File: doc/BRIEF.md
# Auto-Modifying Pointer Address Unit

This block produces the 16-bit data memory address for indirect register-to-memory transfers. It holds three general data pointers and a frame pointer. The frame pointer is a 16-bit base register plus an 8-bit offset register. A transfer names one of these pointers, says whether memory is the read source or the write destination, and asks for no change, a step up or a step down. The block drives the address of that transfer combinationally in the same cycle, because a data memory access finishes within one clock period. It commits the modified pointer on the clock edge of the strobed transfer.

The stepping order depends on the direction. A read uses the pointer as it stands and steps it afterwards. A write steps the pointer first and uses the stepped value. For the frame pointer, the address is the unsigned 16-bit sum of base and offset, and a step acts on the offset alone. The offset wraps within its eight bits and never carries into the base. Each register can also be loaded directly. When a load and a step hit the same register in one cycle, the load wins.

Top module: `ptr_addr_unit`

## Requirements
- R1: With `wr_i`=0 (read source) and a data pointer selected (`sel_i` 0, 1 or 2), `addr_o` equals that pointer's current value. With `mode_i`=01 the pointer holds value+1 after the edge. With `mode_i`=10 it holds value-1 after the edge.
- R2: With `wr_i`=1 (write destination) and a data pointer selected, `addr_o` equals the pointer stepped by `mode_i` (01 = +1, 10 = -1). The pointer holds that same stepped value after the edge.
- R3: With `sel_i`=3 (frame) and no step, `addr_o` equals (base + zero-extended offset) mod 65536.
- R4: Frame steps follow the same order as data pointers. A read addresses base+offset and then steps the offset. A write steps the offset first and addresses base plus the new offset.
- R5: A frame step changes only the offset, modulo 256 (FF+1=00, 00-1=FF). The base register is never changed by a step.
- R6: `mode_i` 00 and 11 both mean no step. The address is the unmodified pointer, and no register changes.
- R7: With `xfer_i`=0, no pointer or offset changes, whatever `sel_i`, `wr_i` and `mode_i` hold.
- R8: A load that targets the register being stepped in the same cycle wins, and the register takes the loaded value. A load to a different register does not block the step.
- R9: After reset, all three data pointers, the base and the offset read zero.
- R10: Data pointers wrap modulo 65536 (FFFF+1=0000, 0000-1=FFFF).
- R11: With `ld_en_i`=1, target code `ld_tgt_i` 0 to 2 loads a data pointer, 3 loads the base, and 4 loads the offset from `ld_val_i[7:0]`. Each load lands on the next edge. Codes 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| xfer_i | input | 1 | Transfer strobe; enables the pointer step |
| sel_i | input | 2 | Pointer select: 0-2 data pointer, 3 frame pointer |
| wr_i | input | 1 | 0 = memory is read source, 1 = memory is write destination |
| mode_i | input | 2 | Step mode: 00 none, 01 up, 10 down, 11 none |
| ld_en_i | input | 1 | Register load enable |
| ld_tgt_i | input | 3 | Load target code |
| ld_val_i | input | 16 | Load value |
| addr_o | output | 16 | Effective address of the current transfer |
| dp_o | output | 48 | Data pointers, pointer n at bits [16n+15:16n] |
| base_o | output | 16 | Frame base register |
| offs_o | output | 8 | Frame offset register |

## Verification
Corrupted pointer state shows up in the same cycle on `addr_o` for any transfer that uses the pointer. It shows up one edge later on the register outputs. Three kinds of error are visible one cycle after the faulty transfer: a pre/post order swapped for one direction, a carry leaking from offset into base, or a lost load priority. Each makes the address differ from the arithmetic expectation by exactly one, or shifts the base. The sweep starts each case at the wrap points 0000, FFFF, 00 and FF, so an off-by-one in wrap handling appears on the first affected transfer.

// File: rtl/pau_pkg.sv
package pau_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Step request carried with each transfer
    typedef enum logic [1:0] {
        MOD_NONE = 2'b00,
        MOD_INC  = 2'b01,
        MOD_DEC  = 2'b10,
        MOD_RSV  = 2'b11
    } mod_e;
endpackage

// File: rtl/pau_step.sv
// One +/-1 stepper; wraps at the register width.
module pau_step #(
    parameter int W = 16
) (
    input  logic [W-1:0]   cur_i,
    input  pau_pkg::mod_e  mode_i,
    output logic [W-1:0]   nxt_o
);
    timeunit 1ns;
    timeprecision 1ps;
    import pau_pkg::*;

    always_comb begin
        unique case (mode_i)
            MOD_INC: nxt_o = cur_i + W'(1);
            MOD_DEC: nxt_o = cur_i - W'(1);
            default: nxt_o = cur_i;
        endcase
    end
endmodule

// File: rtl/pau_addr_sel.sv
// Picks the effective address: pre-step value for reads, post-step for writes.
module pau_addr_sel #(
    parameter int ADDR_W = 16,
    parameter int NUM_DP = 3,
    parameter int OFFS_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic [NUM_DP-1:0][ADDR_W-1:0] dp_cur_i,
    input  logic [NUM_DP-1:0][ADDR_W-1:0] dp_nxt_i,
    input  logic [ADDR_W-1:0]             base_i,
    input  logic [OFFS_W-1:0]             offs_cur_i,
    input  logic [OFFS_W-1:0]             offs_nxt_i,
    input  logic [SEL_W-1:0]              sel_i,
    input  logic                          wr_i,
    output logic [ADDR_W-1:0]             addr_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [SEL_W-1:0] SEL_FRAME = SEL_W'(NUM_DP);

    logic [OFFS_W-1:0] offs_use;

    always_comb begin
        offs_use = wr_i ? offs_nxt_i : offs_cur_i;
        addr_o   = '0;
        for (int i = 0; i < NUM_DP; i++) begin
            if (sel_i == SEL_W'(i)) begin
                addr_o = wr_i ? dp_nxt_i[i] : dp_cur_i[i];
            end
        end
        if (sel_i == SEL_FRAME) begin
            addr_o = base_i + ADDR_W'(offs_use);
        end
    end
endmodule

// File: rtl/ptr_addr_unit.sv
module ptr_addr_unit #(
    parameter int ADDR_W = 16,
    parameter int NUM_DP = 3,
    parameter int OFFS_W = 8,
    parameter int SEL_W  = $clog2(NUM_DP + 1),
    parameter int TGT_W  = $clog2(NUM_DP + 2) < 3 ? 3 : $clog2(NUM_DP + 2)
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     xfer_i,
    input  logic [SEL_W-1:0]         sel_i,
    input  logic                     wr_i,
    input  logic [1:0]               mode_i,
    input  logic                     ld_en_i,
    input  logic [TGT_W-1:0]         ld_tgt_i,
    input  logic [ADDR_W-1:0]        ld_val_i,
    output logic [ADDR_W-1:0]        addr_o,
    output logic [NUM_DP*ADDR_W-1:0] dp_o,
    output logic [ADDR_W-1:0]        base_o,
    output logic [OFFS_W-1:0]        offs_o
);
    timeunit 1ns;
    timeprecision 1ps;
    import pau_pkg::*;

    localparam logic [SEL_W-1:0] SEL_FRAME = SEL_W'(NUM_DP);
    localparam logic [TGT_W-1:0] TGT_BASE  = TGT_W'(NUM_DP);
    localparam logic [TGT_W-1:0] TGT_OFFS  = TGT_W'(NUM_DP + 1);

    typedef struct packed {
        logic [NUM_DP-1:0][ADDR_W-1:0] dp;
        logic [ADDR_W-1:0]             base;
        logic [OFFS_W-1:0]             offs;
    } state_t;

    state_t st_d, st_q;

    mod_e                          mode_s;
    logic [NUM_DP-1:0][ADDR_W-1:0] dp_step;
    logic [OFFS_W-1:0]             offs_step;

    assign mode_s = mod_e'(mode_i);

    // One stepper per data pointer
    for (genvar g = 0; g < NUM_DP; g++) begin : g_dp_step
        pau_step #(.W(ADDR_W)) u_step (
            .cur_i  (st_q.dp[g]),
            .mode_i (mode_s),
            .nxt_o  (dp_step[g])
        );
    end

    // Offset stepper: its width bounds the wrap, so no carry reaches the base
    pau_step #(.W(OFFS_W)) u_offs_step (
        .cur_i  (st_q.offs),
        .mode_i (mode_s),
        .nxt_o  (offs_step)
    );

    pau_addr_sel #(
        .ADDR_W (ADDR_W),
        .NUM_DP (NUM_DP),
        .OFFS_W (OFFS_W),
        .SEL_W  (SEL_W)
    ) u_addr_sel (
        .dp_cur_i   (st_q.dp),
        .dp_nxt_i   (dp_step),
        .base_i     (st_q.base),
        .offs_cur_i (st_q.offs),
        .offs_nxt_i (offs_step),
        .sel_i      (sel_i),
        .wr_i       (wr_i),
        .addr_o     (addr_o)
    );

    always_comb begin
        st_d = st_q;
        // Step first; a load below overrides the same register
        if (xfer_i) begin
            for (int i = 0; i < NUM_DP; i++) begin
                if (sel_i == SEL_W'(i)) begin
                    st_d.dp[i] = dp_step[i];
                end
            end
            if (sel_i == SEL_FRAME) begin
                st_d.offs = offs_step;
            end
        end
        if (ld_en_i) begin
            for (int i = 0; i < NUM_DP; i++) begin
                if (ld_tgt_i == TGT_W'(i)) begin
                    st_d.dp[i] = ld_val_i;
                end
            end
            if (ld_tgt_i == TGT_BASE) begin
                st_d.base = ld_val_i;
            end
            if (ld_tgt_i == TGT_OFFS) begin
                st_d.offs = ld_val_i[OFFS_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dp_o   = st_q.dp;
    assign base_o = st_q.base;
    assign offs_o = st_q.offs;
endmodule

// File: rtl/pau_checker.sv
module pau_checker #(
    parameter int ADDR_W = 16,
    parameter int NUM_DP = 3,
    parameter int OFFS_W = 8,
    parameter int SEL_W  = 2,
    parameter int TGT_W  = 3
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     xfer_i,
    input logic [SEL_W-1:0]         sel_i,
    input logic                     wr_i,
    input logic [1:0]               mode_i,
    input logic                     ld_en_i,
    input logic [TGT_W-1:0]         ld_tgt_i,
    input logic [ADDR_W-1:0]        ld_val_i,
    input logic [ADDR_W-1:0]        addr_o,
    input logic [NUM_DP*ADDR_W-1:0] dp_o,
    input logic [ADDR_W-1:0]        base_o,
    input logic [OFFS_W-1:0]        offs_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [SEL_W-1:0] SEL_FRAME = SEL_W'(NUM_DP);
    localparam logic [TGT_W-1:0] TGT_BASE  = TGT_W'(NUM_DP);
    localparam logic [TGT_W-1:0] TGT_OFFS  = TGT_W'(NUM_DP + 1);

    for (genvar g = 0; g < NUM_DP; g++) begin : g_dp_chk
        // R1: a read addresses the pointer as it stands
        assert_read_uses_current_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (xfer_i && !wr_i && sel_i == SEL_W'(g)) |-> addr_o == dp_o[g*ADDR_W +: ADDR_W]);

        // R2: a stepped write leaves the pointer at the address it used
        assert_write_pre_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (xfer_i && wr_i && sel_i == SEL_W'(g) && !(ld_en_i && ld_tgt_i == TGT_W'(g)))
            |=> dp_o[g*ADDR_W +: ADDR_W] == $past(addr_o));

        // R6: no-step modes leave the pointer alone
        assert_none_mode_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (xfer_i && sel_i == SEL_W'(g) && (mode_i == 2'b00 || mode_i == 2'b11)
             && !(ld_en_i && ld_tgt_i == TGT_W'(g)))
            |=> $stable(dp_o[g*ADDR_W +: ADDR_W]));
    end

    // R3: frame read address is base plus offset
    assert_frame_sum_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (xfer_i && !wr_i && sel_i == SEL_FRAME) |-> addr_o == base_o + ADDR_W'(offs_o));

    // R5: only a load moves the base
    assert_base_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ld_en_i && ld_tgt_i == TGT_BASE) |=> $stable(base_o));

    // R7: no strobe and no load means nothing moves
    assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!xfer_i && !ld_en_i) |=> ($stable(dp_o) && $stable(offs_o)));

    // R8: an offset load wins over a frame step
    assert_load_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ld_en_i && ld_tgt_i == TGT_OFFS) |=> offs_o == $past(ld_val_i[OFFS_W-1:0]));
endmodule

bind ptr_addr_unit pau_checker #(
    .ADDR_W (ADDR_W),
    .NUM_DP (NUM_DP),
    .OFFS_W (OFFS_W),
    .SEL_W  (SEL_W),
    .TGT_W  (TGT_W)
) u_pau_checker (.*);

// File: tb/ptr_addr_unit_bench.sv
module ptr_addr_unit_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = 16;
    localparam int ND = 3;
    localparam int OW = 8;
    localparam int SW = 2;
    localparam int TW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xfer = 1'b0;
    logic [SW-1:0] sel = '0;
    logic          wr = 1'b0;
    logic [1:0]    mode = '0;
    logic          ld_en = 1'b0;
    logic [TW-1:0] ld_tgt = '0;
    logic [AW-1:0] ld_val = '0;
    logic [AW-1:0] addr;
    logic [ND*AW-1:0] dp_flat;
    logic [AW-1:0] base;
    logic [OW-1:0] offs;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [AW-1:0] m_dp [ND];
    logic [AW-1:0] m_base;
    logic [OW-1:0] m_offs;

    // 125 MHz
    always #4 clk = ~clk;

    ptr_addr_unit u_ptr_addr_unit (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .xfer_i   (xfer),
        .sel_i    (sel),
        .wr_i     (wr),
        .mode_i   (mode),
        .ld_en_i  (ld_en),
        .ld_tgt_i (ld_tgt),
        .ld_val_i (ld_val),
        .addr_o   (addr),
        .dp_o     (dp_flat),
        .base_o   (base),
        .offs_o   (offs)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] stepv(input logic [AW-1:0] v, input logic [1:0] m);
        if (m == 2'b01) return v + 16'd1;
        if (m == 2'b10) return v - 16'd1;
        return v;
    endfunction

    function automatic logic [AW-1:0] exp_addr(input int s, input logic w, input logic [1:0] m);
        logic [OW-1:0] o;
        if (s < ND) return w ? stepv(m_dp[s], m) : m_dp[s];
        o = w ? OW'(stepv({8'h00, m_offs}, m)) : m_offs;
        return m_base + {8'h00, o};
    endfunction

    task automatic compare_regs(input string req);
        for (int i = 0; i < ND; i++) chk(req, $sformatf("dp%0d", i), 32'(dp_flat[i*AW +: AW]), 32'(m_dp[i]));
        chk(req, "base", 32'(base), 32'(m_base));
        chk(req, "offs", 32'(offs), 32'(m_offs));
    endtask

    // Called at a falling edge; drives one cycle and checks address then registers
    task automatic xact(input logic x, input int s, input logic w, input logic [1:0] m,
                        input logic le, input int lt, input logic [AW-1:0] lv, input string req);
        xfer = x; sel = SW'(s); wr = w; mode = m; ld_en = le; ld_tgt = TW'(lt); ld_val = lv;
        #1;
        if (x) chk(req, "addr", 32'(addr), 32'(exp_addr(s, w, m)));
        @(posedge clk);
        if (x) begin
            if (s < ND) m_dp[s] = stepv(m_dp[s], m);
            else m_offs = OW'(stepv({8'h00, m_offs}, m));
        end
        if (le) begin
            if (lt < ND) m_dp[lt] = lv;
            else if (lt == ND) m_base = lv;
            else if (lt == ND + 1) m_offs = lv[OW-1:0];
        end
        @(negedge clk);
        xfer = 1'b0; ld_en = 1'b0;
        compare_regs(req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [AW-1:0] seed;
        string req;
        for (int i = 0; i < ND; i++) m_dp[i] = '0;
        m_base = '0;
        m_offs = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare_regs("R9");

        // Sweep select, direction, mode and wrap-point seeds
        for (int s = 0; s <= ND; s++) begin
            for (int w = 0; w < 2; w++) begin
                for (int m = 0; m < 4; m++) begin
                    for (int k = 0; k < 3; k++) begin
                        seed = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : 16'h12A7;
                        if (s < ND) begin
                            xact(1'b0, 0, 1'b0, 2'b00, 1'b1, s, seed, "R11");
                            if (m == 0 || m == 3) req = "R6";
                            else if ((k == 1 && m == 1) || (k == 0 && m == 2)) req = "R10";
                            else req = (w == 0) ? "R1" : "R2";
                        end else begin
                            xact(1'b0, 0, 1'b0, 2'b00, 1'b1, ND, ~seed, "R11");
                            xact(1'b0, 0, 1'b0, 2'b00, 1'b1, ND + 1, {8'h00, seed[7:0]}, "R11");
                            req = (m == 0 || m == 3) ? "R3" : "R4 R5";
                        end
                        xact(1'b1, s, w[0], m[1:0], 1'b0, 0, '0, req);
                    end
                end
            end
        end

        // Load wins over step on the same register
        xact(1'b0, 0, 1'b0, 2'b00, 1'b1, 1, 16'h0100, "R11");
        xact(1'b1, 1, 1'b0, 2'b01, 1'b1, 1, 16'hBEEF, "R8");
        xact(1'b1, 1, 1'b1, 2'b10, 1'b1, 1, 16'h0042, "R8");
        xact(1'b1, ND, 1'b1, 2'b01, 1'b1, ND + 1, 16'h0077, "R8");
        // Load elsewhere does not block the step
        xact(1'b1, 0, 1'b0, 2'b01, 1'b1, 2, 16'h5555, "R8");
        xact(1'b1, ND, 1'b0, 2'b10, 1'b1, ND, 16'hA000, "R8");

        // No strobe: nothing steps
        for (int s = 0; s <= ND; s++) begin
            xact(1'b0, s, 1'b1, 2'b01, 1'b0, 0, '0, "R7");
            xact(1'b0, s, 1'b0, 2'b10, 1'b0, 0, '0, "R7");
        end

        // Unused load codes change nothing
        for (int t = ND + 2; t < 8; t++) begin
            xact(1'b0, 0, 1'b0, 2'b00, 1'b1, t, 16'hDEAD, "R11");
        end

        finish_run();
    end
endmodule